// File: doc/BRIEF.md
# Link Power-State Control Legality Monitor

This block watches the two-bit power-down state of a PCI Express PHY interface together with two control lines: one that asks for receiver detection or datapath loopback, and one that forces the transmitter into electrical idle. The meaning of both control lines depends on the power state. The monitor works out what the current combination means: normal operation, loopback, electrical idle, receiver detect or beacon. It also reports combinations that are not allowed in the current state.

The monitor only observes. It drives nothing back into the PHY. All three inputs are captured in one register stage. The decoded mode and the illegal indication are derived from that register, so they follow the inputs by exactly one clock. When an illegal combination is seen, the block raises a pulse for each offending cycle. It also sets a sticky error flag that only reset clears.

Top module: `pwr_state_monitor`

## Requirements
- R1: With power state 2'b00 (P0) and force-idle low, the mode output is 3'd0 (normal) when detect/loopback is low and 3'd1 (loopback) when it is high.
- R2: With power state P0 and force-idle high, the combination is illegal.
- R3: With power state 2'b01 (P0s), force-idle high gives mode 3'd2 (idle) whatever detect/loopback is, and force-idle low is illegal.
- R4: With power state 2'b10 (P1) and force-idle high, the mode is 3'd2 (idle) when detect/loopback is low and 3'd3 (receiver detect) when it is high. Force-idle low is illegal.
- R5: With power state 2'b11 (P2), force-idle low gives mode 3'd4 (beacon) and force-idle high gives mode 3'd2 (idle). Detect/loopback has no effect, and no combination is illegal.
- R6: The mode and the illegal pulse reflect the inputs sampled at the previous rising clock edge. The pulse is high for exactly the cycles whose captured inputs are illegal.
- R7: The sticky error rises on the clock edge that follows a cycle with the illegal pulse high. It then stays high until reset.
- R8: While the illegal pulse is high, the mode output is 3'd7.
- R9: During and after asynchronous active-low reset, the mode is 3'd0, the illegal pulse is low and the sticky error is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_state | input | 2 | Power state: 00 P0, 01 P0s, 10 P1, 11 P2 |
| det_lpbk | input | 1 | Receiver-detect / loopback request |
| force_idle | input | 1 | Force transmitter electrical idle |
| mode | output | 3 | Decoded mode: 0 normal, 1 loopback, 2 idle, 3 rx detect, 4 beacon, 7 illegal |
| illegal_pulse | output | 1 | High in each cycle whose captured inputs are illegal |
| sticky_err | output | 1 | Set after any illegal cycle, cleared only by reset |

## Verification
All sixteen combinations of power state and the two control lines are applied one after another. This separates each state's legality rule and shows whether detect/loopback is really ignored in P0s and P2. A long run of seeded random combinations then changes the inputs every cycle. It would expose any extra register stage, or any mixing between a cycle and its neighbour, in the mode and pulse outputs. The sticky flag is checked from reset through its first illegal cycle and across later legal cycles. A reset in the middle of the run then confirms that only reset clears it.

// File: rtl/pwr_mon_pkg.sv
package pwr_mon_pkg;

   localparam int unsigned PD_W   = 2;
   localparam int unsigned MODE_W = 3;

   typedef enum logic [PD_W-1:0] {
      PS_ACTIVE  = 2'b00,
      PS_STANDBY = 2'b01,
      PS_LOW     = 2'b10,
      PS_DEEP    = 2'b11
   } pstate_e;

   typedef enum logic [MODE_W-1:0] {
      LM_NORMAL   = 3'd0,
      LM_LOOPBACK = 3'd1,
      LM_IDLE     = 3'd2,
      LM_RXDETECT = 3'd3,
      LM_BEACON   = 3'd4,
      LM_ILLEGAL  = 3'd7
   } lmode_e;

   typedef struct packed {
      logic [PD_W-1:0] pd;
      logic            det;
      logic            fei;
   } ctl_word_t;

endpackage

// File: rtl/pwr_ctl_capture.sv
module pwr_ctl_capture
   import pwr_mon_pkg::*;
#(
   parameter int unsigned PDW = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [PDW-1:0] pd_in,
   input  logic           det_in,
   input  logic           fei_in,
   output ctl_word_t      ctl_q
);

   generate
      if (PDW != PD_W) begin : g_bad_width
         $error("pwr_ctl_capture: PDW must equal %0d", PD_W);
      end
   endgenerate

   // Reset value is a legal P0 normal-mode word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '{pd: PS_ACTIVE, det: 1'b0, fei: 1'b0};
      end else begin
         ctl_q.pd  <= pd_in;
         ctl_q.det <= det_in;
         ctl_q.fei <= fei_in;
      end
   end

endmodule

// File: rtl/pwr_mode_decode.sv
module pwr_mode_decode
   import pwr_mon_pkg::*;
#(
   parameter int unsigned MW = 3
) (
   input  ctl_word_t    ctl,
   output logic [MW-1:0] mode_o,
   output logic          bad_o
);

   generate
      if (MW != MODE_W) begin : g_bad_mw
         $error("pwr_mode_decode: MW must equal %0d", MODE_W);
      end
   endgenerate

   lmode_e lm;
   logic   bad;

   always_comb begin
      lm  = LM_NORMAL;
      bad = 1'b0;
      case (pstate_e'(ctl.pd))
         PS_ACTIVE: begin
            // idle forcing forbidden; detect line picks loopback
            bad = ctl.fei;
            lm  = ctl.det ? LM_LOOPBACK : LM_NORMAL;
         end
         PS_STANDBY: begin
            // idle forcing mandatory; detect line ignored
            bad = ~ctl.fei;
            lm  = LM_IDLE;
         end
         PS_LOW: begin
            // idle forcing mandatory; detect line requests rx detection
            bad = ~ctl.fei;
            lm  = ctl.det ? LM_RXDETECT : LM_IDLE;
         end
         PS_DEEP: begin
            // releasing idle means beacon; always legal
            bad = 1'b0;
            lm  = ctl.fei ? LM_IDLE : LM_BEACON;
         end
         default: begin
            bad = 1'b1;
            lm  = LM_ILLEGAL;
         end
      endcase
      if (bad) lm = LM_ILLEGAL;
   end

   assign mode_o = MW'(lm);
   assign bad_o  = bad;

endmodule

// File: rtl/pwr_err_latch.sv
module pwr_err_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic bad_i,
   output logic sticky_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sticky_o <= 1'b0;
      else if (bad_i) sticky_o <= 1'b1;
   end

endmodule

// File: rtl/pwr_state_monitor.sv
module pwr_state_monitor
   import pwr_mon_pkg::*;
#(
   parameter int unsigned PD_WIDTH   = 2,
   parameter int unsigned MODE_WIDTH = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [PD_WIDTH-1:0]   pd_state,
   input  logic                  det_lpbk,
   input  logic                  force_idle,
   output logic [MODE_WIDTH-1:0] mode,
   output logic                  illegal_pulse,
   output logic                  sticky_err
);

   generate
      if (PD_WIDTH != PD_W) begin : g_chk_pd
         $error("pwr_state_monitor: PD_WIDTH must be %0d", PD_W);
      end
      if (MODE_WIDTH != MODE_W) begin : g_chk_mode
         $error("pwr_state_monitor: MODE_WIDTH must be %0d", MODE_W);
      end
   endgenerate

   ctl_word_t ctl_q;
   logic      bad;

   pwr_ctl_capture #(.PDW(PD_WIDTH)) u_capture (
      .clk    (clk),
      .rst_n  (rst_n),
      .pd_in  (pd_state),
      .det_in (det_lpbk),
      .fei_in (force_idle),
      .ctl_q  (ctl_q)
   );

   pwr_mode_decode #(.MW(MODE_WIDTH)) u_decode (
      .ctl    (ctl_q),
      .mode_o (mode),
      .bad_o  (bad)
   );

   pwr_err_latch u_err (
      .clk      (clk),
      .rst_n    (rst_n),
      .bad_i    (bad),
      .sticky_o (sticky_err)
   );

   assign illegal_pulse = bad;

endmodule

// File: rtl/pwr_state_monitor_chk.sv
module pwr_state_monitor_chk #(
   parameter int unsigned PD_WIDTH   = 2,
   parameter int unsigned MODE_WIDTH = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [PD_WIDTH-1:0]   pd_state,
   input logic                  det_lpbk,
   input logic                  force_idle,
   input logic [MODE_WIDTH-1:0] mode,
   input logic                  illegal_pulse,
   input logic                  sticky_err
);

   p_loopback_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_state == 2'b00 && det_lpbk && !force_idle) |=> (mode == 3'd1));

   p_active_idle_bad_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_state == 2'b00 && force_idle) |=> illegal_pulse);

   p_standby_bad_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_state == 2'b01 && !force_idle) |=> illegal_pulse);

   p_low_bad_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_state == 2'b10 && !force_idle) |=> illegal_pulse);

   p_deep_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_state == 2'b11) |=> !illegal_pulse);

   p_sticky_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_pulse |=> sticky_err);

   p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sticky_err |=> sticky_err);

   p_illegal_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_pulse |-> (mode == 3'd7));

endmodule

bind pwr_state_monitor pwr_state_monitor_chk #(
   .PD_WIDTH   (PD_WIDTH),
   .MODE_WIDTH (MODE_WIDTH)
) i_chk (.*);

// File: tb/test_pwr_state_monitor.sv
module test_pwr_state_monitor;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] pd_state = 2'b00;
   logic       det_lpbk = 1'b0;
   logic       force_idle = 1'b0;
   logic [2:0] mode;
   logic       illegal_pulse;
   logic       sticky_err;

   int checks = 0;
   int errors = 0;
   logic exp_sticky = 1'b0;

   always #2 clk = ~clk;

   pwr_state_monitor i_pwr_state_monitor (
      .clk           (clk),
      .rst_n         (rst_n),
      .pd_state      (pd_state),
      .det_lpbk      (det_lpbk),
      .force_idle    (force_idle),
      .mode          (mode),
      .illegal_pulse (illegal_pulse),
      .sticky_err    (sticky_err)
   );

   function automatic logic model_bad(input logic [1:0] p, input logic d, input logic f);
      case (p)
         2'b00:   return f;
         2'b01:   return ~f;
         2'b10:   return ~f;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [2:0] model_mode(input logic [1:0] p, input logic d, input logic f);
      if (model_bad(p, d, f)) return 3'd7;
      case (p)
         2'b00:   return d ? 3'd1 : 3'd0;
         2'b01:   return 3'd2;
         2'b10:   return d ? 3'd3 : 3'd2;
         default: return f ? 3'd2 : 3'd4;
      endcase
   endfunction

   function automatic string req_of(input logic [1:0] p);
      case (p)
         2'b00:   return "R1/R2";
         2'b01:   return "R3";
         2'b10:   return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // drive at negedge, capture at posedge, check at following negedge
   task automatic apply(input logic [1:0] p, input logic d, input logic f, input string tag);
      logic eb;
      pd_state   = p;
      det_lpbk   = d;
      force_idle = f;
      @(posedge clk);
      @(negedge clk);
      eb = model_bad(p, d, f);
      check({tag, " mode"}, int'(mode), int'(model_mode(p, d, f)));
      check({tag, " R6 pulse"}, int'(illegal_pulse), int'(eb));
      if (eb) check("R8 mode on illegal", int'(mode), 7);
      check("R7 sticky", int'(sticky_err), int'(exp_sticky));
      if (eb) exp_sticky = 1'b1;
   endtask

   initial begin
      #(4 * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h1D0C_5EED));
      // R9: reset state
      repeat (3) @(negedge clk);
      check("R9 mode", int'(mode), 0);
      check("R9 pulse", int'(illegal_pulse), 0);
      check("R9 sticky", int'(sticky_err), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // legal-only sweep first: sticky must stay low (R7)
      apply(2'b00, 1'b0, 1'b0, "R1 normal");
      apply(2'b00, 1'b1, 1'b0, "R1 loopback");
      apply(2'b01, 1'b0, 1'b1, "R3 idle det0");
      apply(2'b01, 1'b1, 1'b1, "R3 idle det1");
      apply(2'b10, 1'b0, 1'b1, "R4 idle");
      apply(2'b10, 1'b1, 1'b1, "R4 rxdet");
      apply(2'b11, 1'b0, 1'b0, "R5 beacon det0");
      apply(2'b11, 1'b1, 1'b0, "R5 beacon det1");
      apply(2'b11, 1'b0, 1'b1, "R5 idle det0");
      apply(2'b11, 1'b1, 1'b1, "R5 idle det1");

      // illegal corners
      apply(2'b00, 1'b0, 1'b1, "R2 fei in P0");
      apply(2'b00, 1'b1, 1'b1, "R2 fei+det in P0");
      apply(2'b01, 1'b0, 1'b0, "R3 no fei in P0s");
      apply(2'b01, 1'b1, 1'b0, "R3 no fei det in P0s");
      apply(2'b10, 1'b0, 1'b0, "R4 no fei in P1");
      apply(2'b10, 1'b1, 1'b0, "R4 no fei det in P1");
      apply(2'b00, 1'b0, 1'b0, "R1 back to normal");

      // random: inputs change every cycle
      for (int i = 0; i < 400; i++) begin
         logic [2:0] r;
         logic [1:0] p;
         r = 3'($urandom);
         p = 2'($urandom);
         apply(p, r[0], r[1], req_of(p));
      end

      // R9: reset mid-run clears sticky
      rst_n = 1'b0;
      #1;
      check("R9 async mode", int'(mode), 0);
      check("R9 async pulse", int'(illegal_pulse), 0);
      check("R9 async sticky", int'(sticky_err), 0);
      @(negedge clk);
      rst_n = 1'b1;
      exp_sticky = 1'b0;
      apply(2'b10, 1'b1, 1'b1, "R4 after reset");
      apply(2'b11, 1'b1, 1'b0, "R5 after reset");

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule